// File: doc/BRIEF.md
# Windowed Relinearization Multiply-Accumulator

This block does the key-product half of a relinearization step for a polynomial ring scheme. A ciphertext coefficient is held as a multi-word integer. The block cuts it into W-bit digits that go to an external forward transform. Each digit is narrower than every residue prime, so it is already a valid residue for each of them and goes to the transform unchanged, with no residue conversion per digit.

The transformed digit values come back as a stream. For each value the block reads the matching evaluation-key point from a key memory and multiplies the two. It reduces the product modulo the active prime and adds it into a per-point, per-prime accumulator. All of this stays in the transform domain, so a whole relinearization needs only one inverse transform, after the last digit.

A start input clears the accumulators and latches the circuit level. The level fixes how many primes are active and how many digits are consumed. The key layout is the one built for level zero. Higher levels use the subset of those keys at the same digit indices, so keys are never rebuilt. When the last value has been absorbed, a one-cycle done pulse tells the inverse-transform stage to read the results through the read port.

Top module: `relin_mac`

## Requirements
- R1: `dig_out` is bits [W*sel, W*sel+W) of `coef_in`, where word 0 of `coef_in` holds bits 31:0 and higher words hold higher bits. Bits past the top of `coef_in` read as zero. The output follows the inputs in the same cycle, with no register.
- R2: At level L the digit count is eta = ceil((T0-L)*BP / W). With the defaults (T0=3, BP=25, W=16) this is 5, 4 and 2 for levels 0, 1 and 2. Exactly eta * (T0-L) * NPTS accepted values complete a run.
- R3: The key address for digit tau, prime j and point k is (tau*T0 + j)*NPTS + k, whatever the level. Within a run, k advances fastest, then j, then tau.
- R4: At level L exactly T0-L primes are active, namely primes 0 .. T0-L-1. Accumulators of inactive primes stay zero after a start.
- R5: Each key-by-value product is reduced modulo its prime before it is added. Every accumulator holds (sum of key*value) mod p_j and is always below p_j.
- R6: `done` goes high for exactly one cycle, in the cycle after the final value is accepted, and never earlier. `in_valid` has no effect while the block is idle.
- R7: `start` clears every accumulator, latches `level` and begins a new run. This also applies during a run, which it abandons.
- R8: After reset, `busy` and `done` are low and every accumulator reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_in | input | CW (96) | Ciphertext coefficient, little-endian 32-bit words |
| dig_sel | input | TAUW (3) | Digit index to extract |
| dig_out | output | W (16) | Selected digit |
| start | input | 1 | Clear accumulators, latch level, begin run |
| level | input | LVW (2) | Circuit level, below T0 |
| in_valid | input | 1 | Transformed digit value present |
| in_data | input | BP (25) | Transformed digit value, below the current prime |
| key_addr | output | KAW (7) | Evaluation-key read address |
| key_data | input | BP (25) | Key point at `key_addr`, same cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_addr | input | RAW (5) | Accumulator index j*NPTS + k |
| rd_data | output | BP (25) | Accumulator value |

## Verification
The digit splitter is combinational, so the bench samples `dig_out` one time step after setting the coefficient and digit index. The key address is a decode of the beat counters and is checked in the same half-cycle that each value is presented, before the edge that consumes it. An accepted value is in the accumulator right after its rising edge. `done` is sampled on the falling edge that follows the final beat and again one cycle later to confirm it is a single pulse. Accumulators are read through the combinational read port on falling edges only, once the run is complete, after stray idle input, and after a start that interrupts a run.

// File: rtl/relin_mac.sv
module relin_mac #(
  parameter int W      = 16,
  parameter int BP     = 25,
  parameter int T0     = 3,
  parameter int NPTS   = 8,
  parameter logic [T0*BP-1:0] PRIMES = {25'd33554371, 25'd33554383, 25'd33554393},
  localparam int CW     = ((T0*BP + 31) / 32) * 32,
  localparam int MAXETA = (T0*BP + W - 1) / W,
  localparam int TAUW   = $clog2(CW / W),
  localparam int LVW    = $clog2(T0 + 1),
  localparam int NACC   = T0 * NPTS,
  localparam int KAW    = $clog2(MAXETA * NACC),
  localparam int RAW    = $clog2(NACC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   coef_in,
  input  logic [TAUW-1:0] dig_sel,
  output logic [W-1:0]    dig_out,
  input  logic            start,
  input  logic [LVW-1:0]  level,
  input  logic            in_valid,
  input  logic [BP-1:0]   in_data,
  output logic [KAW-1:0]  key_addr,
  input  logic [BP-1:0]   key_data,
  output logic            busy,
  output logic            done,
  input  logic [RAW-1:0]  rd_addr,
  output logic [BP-1:0]   rd_data
);

  localparam int TCW = $clog2(MAXETA + 1);
  localparam int JCW = $clog2(T0 + 1);
  localparam int KCW = $clog2(NPTS + 1);

  logic [BP-1:0]  acc [NACC];
  logic [LVW-1:0] lvl_q;
  logic [TCW-1:0] tau_q;
  logic [JCW-1:0] j_q;
  logic [KCW-1:0] k_q;
  logic           busy_q, done_q;

  int             t_act, eta;
  logic [BP-1:0]  cur_p;
  logic [2*BP-1:0] prod;
  logic [BP-1:0]  prod_m;
  logic [BP:0]    sum;
  logic [BP-1:0]  acc_n;
  logic [RAW-1:0] idx;
  logic           fire, k_end, j_end, last;

  assign dig_out = W'(coef_in >> (W * int'(dig_sel)));

  assign t_act = T0 - int'(lvl_q);
  assign eta   = (t_act * BP + W - 1) / W;

  assign cur_p    = PRIMES[int'(j_q)*BP +: BP];
  assign idx      = RAW'(int'(j_q) * NPTS + int'(k_q));
  assign key_addr = KAW'((int'(tau_q) * T0 + int'(j_q)) * NPTS + int'(k_q));

  assign prod   = {{BP{1'b0}}, key_data} * {{BP{1'b0}}, in_data};
  assign prod_m = BP'(prod % {{BP{1'b0}}, cur_p});
  assign sum    = {1'b0, acc[idx]} + {1'b0, prod_m};
  assign acc_n  = (sum >= {1'b0, cur_p}) ? BP'(sum - {1'b0, cur_p}) : sum[BP-1:0];

  assign fire  = busy_q && in_valid;
  assign k_end = int'(k_q) == NPTS - 1;
  assign j_end = int'(j_q) == t_act - 1;
  assign last  = k_end && j_end && (int'(tau_q) == eta - 1);

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = (int'(rd_addr) < NACC) ? acc[rd_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      lvl_q  <= '0;
      tau_q  <= '0;
      j_q    <= '0;
      k_q    <= '0;
      for (int e = 0; e < NACC; e++) acc[e] <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        lvl_q  <= level;
        tau_q  <= '0;
        j_q    <= '0;
        k_q    <= '0;
        for (int e = 0; e < NACC; e++) acc[e] <= '0;
      end else if (fire) begin
        acc[idx] <= acc_n;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          tau_q  <= '0;
          j_q    <= '0;
          k_q    <= '0;
        end else if (!k_end) begin
          k_q <= k_q + 1'b1;
        end else begin
          k_q <= '0;
          if (!j_end) begin
            j_q <= j_q + 1'b1;
          end else begin
            j_q   <= '0;
            tau_q <= tau_q + 1'b1;
          end
        end
      end
    end
  end

  generate
    for (genvar e = 0; e < NACC; e++) begin : g_acc_chk
      a_r5_acc_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        acc[e] < PRIMES[(e / NPTS)*BP +: BP]);
    end
  endgenerate

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r6_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(fire));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(acc[0]) && !busy_q);

  a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> int'(key_addr) < MAXETA * NACC);

  a_r4_prime_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> int'(j_q) < T0 - int'(lvl_q));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc[NACC-1] == '0) && busy_q);

endmodule

// File: tb/relin_mac_tb.sv
module relin_mac_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, BP = 25, T0 = 3, NPTS = 8;
  localparam int CW = 96, TAUW = 3, LVW = 2, KAW = 7, RAW = 5, NACC = T0*NPTS;
  localparam longint P [T0] = '{33554393, 33554383, 33554371};

  localparam int NV = 10;
  localparam logic [CW+TAUW+W-1:0] DVEC [NV] = '{
    {96'h0123_4567_89AB_CDEF_FEDC_BA98, 3'd0, 16'hBA98},
    {96'h0123_4567_89AB_CDEF_FEDC_BA98, 3'd1, 16'hFEDC},
    {96'h0123_4567_89AB_CDEF_FEDC_BA98, 3'd2, 16'hCDEF},
    {96'h0123_4567_89AB_CDEF_FEDC_BA98, 3'd3, 16'h89AB},
    {96'h0123_4567_89AB_CDEF_FEDC_BA98, 3'd4, 16'h4567},
    {96'h0123_4567_89AB_CDEF_FEDC_BA98, 3'd5, 16'h0123},
    {96'h8000_0000_0001_0000_0000_FFFF, 3'd0, 16'hFFFF},
    {96'h8000_0000_0001_0000_0000_FFFF, 3'd3, 16'h0001},
    {96'h8000_0000_0001_0000_0000_FFFF, 3'd5, 16'h8000},
    {96'h8000_0000_0001_0000_0000_FFFF, 3'd7, 16'h0000}
  };

  logic            clk = 0, rst_n = 0;
  logic [CW-1:0]   coef_in = '0;
  logic [TAUW-1:0] dig_sel = '0;
  logic [W-1:0]    dig_out;
  logic            start = 0;
  logic [LVW-1:0]  level = '0;
  logic            in_valid = 0;
  logic [BP-1:0]   in_data = '0;
  logic [KAW-1:0]  key_addr;
  logic [BP-1:0]   key_data;
  logic            busy, done;
  logic [RAW-1:0]  rd_addr = '0;
  logic [BP-1:0]   rd_data;

  int nchk = 0, nfail = 0;
  longint macc [NACC];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint keyv(int a);
    int j = (a / NPTS) % T0;
    return P[j] - 1 - longint'((a * 40503) % 1000);
  endfunction

  function automatic longint valv(int tau, int j, int k);
    return P[j] - 1 - longint'(tau*37 + k*11 + j*5);
  endfunction

  assign key_data = BP'(keyv(int'(key_addr)));

  relin_mac u_dut (
    .clk(clk), .rst_n(rst_n), .coef_in(coef_in), .dig_sel(dig_sel), .dig_out(dig_out),
    .start(start), .level(level), .in_valid(in_valid), .in_data(in_data),
    .key_addr(key_addr), .key_data(key_data), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_accs(string req);
    for (int e = 0; e < NACC; e++) begin
      rd_addr = RAW'(e);
      #1;
      check(req, longint'(rd_data), macc[e]);
    end
  endtask

  task automatic do_start(int lv);
    @(negedge clk);
    start = 1; level = LVW'(lv); in_valid = 0;
    @(negedge clk);
    start = 0;
    for (int e = 0; e < NACC; e++) macc[e] = 0;
  endtask

  // R2 R3 R5 R6: full run at level lv; beats_max cuts the run short when >= 0
  task automatic run_level(int lv, bit bubble, int beats_max);
    int t = T0 - lv;
    int eta = (t*BP + W - 1) / W;
    int n = 0;
    do_start(lv);
    for (int tau = 0; tau < eta; tau++)
      for (int j = 0; j < t; j++)
        for (int k = 0; k < NPTS; k++) begin
          if (beats_max >= 0 && n >= beats_max) return;
          if (bubble && k == 3) begin
            in_valid = 0;
            @(negedge clk);
          end
          in_valid = 1;
          in_data = BP'(valv(tau, j, k));
          #1;
          check("R3 key address", longint'(key_addr), longint'((tau*T0 + j)*NPTS + k));
          check("R6 no early done", longint'(done), 0);
          macc[j*NPTS+k] = (macc[j*NPTS+k] + (keyv((tau*T0+j)*NPTS+k) * valv(tau,j,k)) % P[j]) % P[j];
          n++;
          @(negedge clk);
          in_valid = 0;
        end
    check("R6 done after last beat", longint'(done), 1);
    check("R2 busy cleared at end", longint'(busy), 0);
    @(negedge clk);
    check("R6 done single cycle", longint'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int e = 0; e < NACC; e++) macc[e] = 0;
    #(CLK_PERIOD*2 + 3);
    check("R8 busy at reset", longint'(busy), 0);
    check("R8 done at reset", longint'(done), 0);
    check_accs("R8 accumulator at reset");
    @(negedge clk);
    rst_n = 1;

    // R1 digit table
    for (int v = 0; v < NV; v++) begin
      coef_in = DVEC[v][TAUW+W +: CW];
      dig_sel = DVEC[v][W +: TAUW];
      #1;
      check("R1 digit split", longint'(dig_out), longint'(DVEC[v][W-1:0]));
    end

    // R2 R4 R5 at each level
    run_level(0, 0, -1);
    check_accs("R5 level 0 accumulators");
    run_level(1, 1, -1);
    check_accs("R4 level 1 accumulators");
    run_level(2, 0, -1);
    check_accs("R4 level 2 accumulators");

    // R6 idle input ignored
    @(negedge clk);
    in_valid = 1; in_data = 25'd12345;
    repeat (3) @(negedge clk);
    in_valid = 0;
    check("R6 idle busy", longint'(busy), 0);
    check("R6 idle done", longint'(done), 0);
    check_accs("R6 idle accumulators");

    // R7 start during a run clears and restarts
    run_level(0, 0, 20);
    check("R7 mid-run busy", longint'(busy), 1);
    run_level(2, 1, -1);
    check_accs("R7 restart accumulators");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule